// File: doc/BRIEF.md
# Branch Resolve Unit

The branch resolve unit decides whether a control-transfer instruction is taken and what the program counter becomes. It covers three kinds of transfer: a conditional jump to a 16-bit absolute target, a conditional jump by a signed byte displacement, and a loop instruction that decrements a counter and then jumps relative while the new count is nonzero. The condition is a 4-bit code that is tested against the carry, zero, sign and overflow flags. The upper bit of the code inverts the test that the lower three bits select.

A request is presented for one cycle with `req_valid` high. The unit registers the decision, the new program counter and the decremented count, and shows them on the next cycle with `res_valid` high. Relative targets are measured from the address of the instruction that follows the branch, and they wrap modulo 2^16. The loop instruction leaves the flags alone. Its decremented count comes back on `cnt_next` with `cnt_write` set, so the surrounding core can write it back.

Top module: `branch_resolve_unit`

## Requirements
- R1: The result appears one cycle after a request. `res_valid` is high in exactly the cycle after each cycle with `req_valid` high. When no request is accepted, `taken`, `new_pc`, `cnt_next` and `cnt_write` keep their values.
- R2: Code 4'b0000 is never taken and code 4'b1000 is always taken, whatever the flags.
- R3: The flag tests come in complement pairs, and bit 3 inverts the lower-three-bit test. 0110 is Z=1 and 1110 is Z=0. 0101 is S=1 and 1101 is S=0. 0100 is V=1 and 1100 is V=0.
- R4: The signed codes are 0001 (less than, S XOR V = 1), 1001 (greater or equal, S XOR V = 0), 0010 (less or equal, Z OR (S XOR V) = 1) and 1010 (greater than, Z OR (S XOR V) = 0).
- R5: The carry and unsigned codes are 0111 (C=1, unsigned less than), 1111 (C=0, unsigned greater or equal), 0011 (C OR Z = 1, unsigned less or equal) and 1011 (C OR Z = 0, unsigned greater than).
- R6: Operation 2'b00 is the absolute jump. When it is taken, `new_pc` equals `abs_target`. `cnt_write` is 0.
- R7: Operation 2'b01 is the relative jump. When it is taken, `new_pc` equals `next_pc` plus the sign-extended `rel_disp` (-128..+127), modulo 2^16. `cnt_write` is 0.
- R8: Any request that is not taken gives `new_pc` equal to `next_pc`.
- R9: Operation 2'b10 is the decrement-and-jump. `cnt_next` is `loop_cnt` minus 1 modulo 2^8 and `cnt_write` is 1. The jump is taken exactly when that result is nonzero, with a relative target as in R7. The condition code and the flags have no effect.
- R10: Operation 2'b11 is reserved. It is never taken, `new_pc` equals `next_pc`, and `cnt_write` is 0.
- R11: While `rst_n` is low, `res_valid`, `taken` and `cnt_write` are 0, and `new_pc` and `cnt_next` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| op | input | 2 | 00 absolute, 01 relative, 10 decrement-and-jump, 11 reserved |
| cond | input | 4 | Condition code |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_v | input | 1 | Overflow flag |
| next_pc | input | 16 | Address of the following instruction |
| abs_target | input | 16 | Absolute jump target |
| rel_disp | input | 8 | Signed displacement |
| loop_cnt | input | 8 | Current loop counter value |
| res_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| new_pc | output | 16 | Resolved program counter |
| cnt_next | output | 8 | Decremented counter |
| cnt_write | output | 1 | Counter write-back strobe |

## Verification
The hardest cases to reach are the ones where the program counter wraps. One is a backward displacement from a low address. The other is a forward displacement from just below 16'hFFFF. The stimulus reaches both by sweeping every displacement from three base addresses, one of them near each end of the address space.

A second case is the decrement-and-jump at a count of 1, the only count that falls through, and at a count of 0, which wraps to 255 and is taken. Every count is swept, and the condition code and flags are scrambled at the same time to show they have no effect. Every code is also tried against all 16 flag combinations.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    OP_ABS  = 2'b00,
    OP_REL  = 2'b01,
    OP_LOOP = 2'b10,
    OP_NONE = 2'b11
  } br_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } flags_t;
endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  input  flags_t            flags,
  output logic              hit
);
  localparam int SEL_W  = CODE_W - 1;
  localparam int N_BASE = 1 << SEL_W;

  logic [N_BASE-1:0] base;
  logic              lt_signed;

  always_comb begin
    lt_signed = flags.s ^ flags.v;
    base      = '0;
    base[1]   = lt_signed;
    base[2]   = flags.z | lt_signed;
    base[3]   = flags.c | flags.z;
    base[4]   = flags.v;
    base[5]   = flags.s;
    base[6]   = flags.z;
    base[7]   = flags.c;
  end

  assign hit = base[code[SEL_W-1:0]] ^ code[CODE_W-1];
endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   next_pc,
  input  logic [PC_W-1:0]   abs_target,
  input  logic [DISP_W-1:0] disp,
  input  logic              use_rel,
  output logic [PC_W-1:0]   target
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] rel_target;

  assign disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign rel_target = next_pc + disp_ext;
  assign target     = use_rel ? rel_target : abs_target;
endmodule

// File: rtl/bru_loop_dec.sv
module bru_loop_dec #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] cnt_out,
  output logic             nonzero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign cnt_out = cnt_in - ONE;
  assign nonzero = |cnt_out;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int CNT_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        op,
  input  logic [CODE_W-1:0] cond,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_v,
  input  logic [PC_W-1:0]   next_pc,
  input  logic [PC_W-1:0]   abs_target,
  input  logic [DISP_W-1:0] rel_disp,
  input  logic [CNT_W-1:0]  loop_cnt,
  output logic              res_valid,
  output logic              taken,
  output logic [PC_W-1:0]   new_pc,
  output logic [CNT_W-1:0]  cnt_next,
  output logic              cnt_write
);
  flags_t          flags;
  br_op_e          op_e;
  logic            cond_hit;
  logic            use_rel;
  logic [PC_W-1:0] target;
  logic [CNT_W-1:0] dec_val;
  logic            dec_nz;

  logic             taken_d;
  logic [PC_W-1:0]  pc_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cntwr_d;

  assign flags = '{c: flag_c, z: flag_z, s: flag_s, v: flag_v};
  assign op_e  = br_op_e'(op);

  bru_cond_eval #(.CODE_W(CODE_W)) u_cond (
    .code  (cond),
    .flags (flags),
    .hit   (cond_hit)
  );

  assign use_rel = (op_e != OP_ABS);

  bru_target_gen #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .next_pc    (next_pc),
    .abs_target (abs_target),
    .disp       (rel_disp),
    .use_rel    (use_rel),
    .target     (target)
  );

  bru_loop_dec #(.CNT_W(CNT_W)) u_dec (
    .cnt_in  (loop_cnt),
    .cnt_out (dec_val),
    .nonzero (dec_nz)
  );

  always_comb begin
    taken_d = 1'b0;
    cntwr_d = 1'b0;
    cnt_d   = dec_val;
    unique case (op_e)
      OP_ABS:  taken_d = cond_hit;
      OP_REL:  taken_d = cond_hit;
      OP_LOOP: begin
        taken_d = dec_nz;
        cntwr_d = 1'b1;
      end
      default: taken_d = 1'b0;
    endcase
    pc_d = taken_d ? target : next_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken     <= 1'b0;
      new_pc    <= '0;
      cnt_next  <= '0;
      cnt_write <= 1'b0;
    end else if (req_valid) begin
      taken     <= taken_d;
      new_pc    <= pc_d;
      cnt_next  <= cnt_d;
      cnt_write <= cntwr_d;
    end
  end
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int CNT_W  = 8,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        op,
  input logic [CODE_W-1:0] cond,
  input logic              flag_z,
  input logic [PC_W-1:0]   next_pc,
  input logic [PC_W-1:0]   abs_target,
  input logic [CNT_W-1:0]  loop_cnt,
  input logic              res_valid,
  input logic              taken,
  input logic [PC_W-1:0]   new_pc,
  input logic [CNT_W-1:0]  cnt_next,
  input logic              cnt_write
);
  localparam logic [CODE_W-1:0] C_NEVER  = '0;
  localparam logic [CODE_W-1:0] C_ALWAYS = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(req_valid)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(new_pc) && $stable(taken) && $stable(cnt_write)); // R1

  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op != 2'b10 && cond == C_NEVER |=> !taken); // R2

  AST_ALWAYS_ABS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op == 2'b00 && cond == C_ALWAYS |=> taken && new_pc == $past(abs_target)); // R6

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> taken || new_pc == $past(next_pc)); // R8

  AST_LOOP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op == 2'b10 |=> cnt_write && cnt_next == CNT_W'($past(loop_cnt) - ONE)); // R9

  AST_LOOP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op == 2'b10 |=> taken == ($past(loop_cnt) != ONE)); // R9

  AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op == 2'b11 |=> !taken && !cnt_write); // R10

  AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op == 2'b00 && cond[CODE_W-2:0] == 3'b110 |=> taken == ($past(flag_z) ^ $past(cond[CODE_W-1]))); // R3
endmodule

bind branch_resolve_unit bru_checker #(
  .PC_W(PC_W), .DISP_W(DISP_W), .CNT_W(CNT_W), .CODE_W(CODE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .op         (op),
  .cond       (cond),
  .flag_z     (flag_z),
  .next_pc    (next_pc),
  .abs_target (abs_target),
  .loop_cnt   (loop_cnt),
  .res_valid  (res_valid),
  .taken      (taken),
  .new_pc     (new_pc),
  .cnt_next   (cnt_next),
  .cnt_write  (cnt_write)
);

// File: tb/sim_branch_resolve_unit.sv
`timescale 1ns/1ps
module sim_branch_resolve_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  op;
  logic [3:0]  cond;
  logic        flag_c, flag_z, flag_s, flag_v;
  logic [15:0] next_pc, abs_target;
  logic [7:0]  rel_disp, loop_cnt;
  logic        res_valid, taken, cnt_write;
  logic [15:0] new_pc;
  logic [7:0]  cnt_next;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  branch_resolve_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .cond(cond),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v),
    .next_pc(next_pc), .abs_target(abs_target), .rel_disp(rel_disp),
    .loop_cnt(loop_cnt), .res_valid(res_valid), .taken(taken),
    .new_pc(new_pc), .cnt_next(cnt_next), .cnt_write(cnt_write)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit want(input logic [3:0] cc, input bit c, z, s, v);
    case (cc)
      4'h0: return 1'b0;
      4'h8: return 1'b1;
      4'h7: return c;
      4'hF: return !c;
      4'h6: return z;
      4'hE: return !z;
      4'h5: return s;
      4'hD: return !s;
      4'h4: return v;
      4'hC: return !v;
      4'h1: return s != v;
      4'h9: return s == v;
      4'h2: return z || (s != v);
      4'hA: return !z && (s == v);
      4'h3: return c || z;
      default: return !c && !z;
    endcase
  endfunction

  // drive at negedge, result sampled at the following negedge
  task automatic issue(input logic [1:0] o, input logic [3:0] cc, input logic [3:0] f,
                       input logic [15:0] npc, input logic [15:0] abst,
                       input logic [7:0] d, input logic [7:0] cnt);
    req_valid = 1'b1; op = o; cond = cc;
    {flag_c, flag_z, flag_s, flag_v} = f;
    next_pc = npc; abs_target = abst; rel_disp = d; loop_cnt = cnt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic int rel_exp(input logic [15:0] npc, input logic [7:0] d);
    return (int'(npc) + int'($signed(d))) & 32'hFFFF;
  endfunction

  initial begin
    int exp_pc;
    bit exp_t;
    rst_n = 1'b0; req_valid = 1'b0; op = 2'b00; cond = 4'h0;
    {flag_c, flag_z, flag_s, flag_v} = 4'h0;
    next_pc = 16'h0; abs_target = 16'h0; rel_disp = 8'h0; loop_cnt = 8'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!res_valid && !taken && !cnt_write && new_pc == 0 && cnt_next == 0,
        "R11 reset", {res_valid, taken, cnt_write}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid, "R1 idle after reset", res_valid, 0);

    // R2..R5, R6, R8: every code against every flag set, absolute jumps
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        issue(2'b00, cc[3:0], f[3:0], 16'h1234 + 16'(f), 16'hA000 + 16'(cc * 16 + f), 8'h00, 8'h55);
        exp_t  = want(cc[3:0], f[3], f[2], f[1], f[0]);
        exp_pc = exp_t ? 'hA000 + cc * 16 + f : 'h1234 + f;
        chk(res_valid, "R1 valid", res_valid, 1);
        chk(taken == exp_t, cc == 0 || cc == 8 ? "R2 code" :
            (cc[2:0] == 3 || cc[2:0] == 7) ? "R5 code" :
            (cc[2:0] == 1 || cc[2:0] == 2) ? "R4 code" : "R3 code",
            {cc, 3'b0, taken}, {cc, 3'b0, exp_t});
        chk(new_pc == 16'(exp_pc), exp_t ? "R6 abs target" : "R8 fall through", new_pc, exp_pc);
        chk(!cnt_write, "R6 no count write", cnt_write, 0);
      end
    end

    // R7: every displacement from three bases, always / never codes
    for (int b = 0; b < 3; b++) begin
      for (int d = 0; d < 256; d++) begin
        logic [15:0] base;
        base = (b == 0) ? 16'h0005 : (b == 1) ? 16'hFFF0 : 16'h8000;
        issue(2'b01, 4'h8, 4'(d), base, 16'hDEAD, d[7:0], 8'h00);
        chk(taken && new_pc == 16'(rel_exp(base, d[7:0])), "R7 relative target",
            new_pc, rel_exp(base, d[7:0]));
        chk(!cnt_write, "R7 no count write", cnt_write, 0);
      end
    end
    issue(2'b01, 4'h0, 4'hF, 16'h4000, 16'hDEAD, 8'h80, 8'h00);
    chk(!taken && new_pc == 16'h4000, "R8 relative not taken", new_pc, 16'h4000);

    // R9: every counter value, condition and flags scrambled
    for (int n = 0; n < 256; n++) begin
      issue(2'b10, n[3:0], n[7:4], 16'h0100, 16'hBEEF, 8'hFC, n[7:0]);
      exp_t = (n != 1);
      chk(cnt_write && cnt_next == 8'(n - 1), "R9 count", cnt_next, (n - 1) & 255);
      chk(taken == exp_t, "R9 taken", taken, exp_t);
      chk(new_pc == (exp_t ? 16'h00FC : 16'h0100), "R9 target", new_pc,
          exp_t ? 'h00FC : 'h0100);
    end

    // R10: reserved op
    for (int cc = 0; cc < 16; cc++) begin
      issue(2'b11, cc[3:0], 4'hF, 16'h2222, 16'h3333, 8'h10, 8'h05);
      chk(!taken && !cnt_write && new_pc == 16'h2222, "R10 reserved", new_pc, 16'h2222);
    end

    // R1: hold while idle
    issue(2'b00, 4'h8, 4'h0, 16'h1111, 16'h7777, 8'h00, 8'h09);
    op = 2'b10; next_pc = 16'h9999; abs_target = 16'h0; loop_cnt = 8'h03;
    @(negedge clk);
    chk(!res_valid, "R1 valid drops", res_valid, 0);
    chk(taken && new_pc == 16'h7777 && !cnt_write, "R1 outputs hold", new_pc, 16'h7777);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule